// File: doc/BRIEF.md
# Prescaled PWM Output Controller

This block generates a single pulse-width-modulated output from its own clock. One 32-bit control word configures it. A 13-bit scale field divides the clock by scale+1 to make a slow tick. Every period is 256 ticks long. The output is high for the first `width` ticks of each period. A separate full-duty bit forces the output high for the whole period, whatever the width field holds. An enable bit gates the whole function.

Software writes the control word through a plain write-enable and data bus and can read it back. The write port has no handshake and no back-pressure: a write is taken on every cycle in which `cfg_we` is high. Every write takes effect at once. The prescaler and the tick counter restart from zero, and the running period is abandoned. Clearing the enable drives the output low on the next cycle without finishing the period.

Control word layout:
- Bits [12:0] hold the scale.
- Bits [23:16] hold the width.
- Bit 24 is full duty.
- Bit 31 is enable.
- Bits [30:25] and [15:13] are reserved. They read as zero and ignore writes.

Top module: `pwm_prescaled_ctl`

## Requirements
- R1: A synchronous active-high reset drives `pwm_out` low and makes `cfg_rdata` read 0.
- R2: `cfg_rdata` returns the last written word with bits [30:25] and [15:13] forced to zero. The read mask is 0x81FF_1FFF.
- R3: One tick lasts scale+1 clock cycles, where scale is bits [12:0]. One PWM period lasts 256*(scale+1) cycles and then repeats.
- R4: When bit 31 is 1 and bit 24 is 0, `pwm_out` is high for the first width*(scale+1) cycles of each period and low for the rest. Width is bits [23:16].
- R5: When bit 31 is 1, bit 24 is 0 and width is 0, `pwm_out` stays low.
- R6: When bits 31 and 24 are both 1, `pwm_out` stays high for every cycle, whatever the width field holds.
- R7: A write with bit 31 clear drives `pwm_out` low from the cycle after the write, even in the middle of a high phase.
- R8: Any write restarts timing. In the cycle after the write, a new period begins at tick 0, and the running period is abandoned.
- R9: Writes to the reserved bits have no effect on `pwm_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back, reserved bits zero |
| pwm_out | output | 1 | PWM output, inactive level 0 |

## Verification
Every internal state in this block shows up on `pwm_out` within one period.

- A prescaler that compares against the wrong limit stretches or shrinks each tick. The high phase then has the wrong length, which is visible at the first falling edge.
- A tick counter that is not cleared on a write shifts the high phase. This is visible in the cycle after the write: the output is low where a fresh period must start high.
- A wrong mask shows on `cfg_rdata` in the cycle after the write.

The bench compares every sampled output cycle against the expected waveform over two full periods, so a fault cannot hide between samples.

// File: rtl/pwm_ctl_pkg.sv
`timescale 1ns/1ps
package pwm_ctl_pkg;
  localparam int REG_W     = 32;
  localparam int SCALE_LSB = 0;
  localparam int SCALE_W   = 13;
  localparam int WIDTH_LSB = 16;
  localparam int WIDTH_W   = 8;
  localparam int FULL_BIT  = 24;
  localparam int EN_BIT    = 31;

  // Bits that hold state; everything else reads back as zero.
  localparam logic [REG_W-1:0] KEEP_MASK =
      (((REG_W'(1) << SCALE_W) - REG_W'(1)) << SCALE_LSB) |
      (((REG_W'(1) << WIDTH_W) - REG_W'(1)) << WIDTH_LSB) |
      (REG_W'(1) << FULL_BIT) |
      (REG_W'(1) << EN_BIT);

  typedef struct packed {
    logic               en;
    logic               full;
    logic [WIDTH_W-1:0] width;
    logic [SCALE_W-1:0] scale;
  } pwm_cfg_t;

  function automatic pwm_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    pwm_cfg_t c;
    c.en    = w[EN_BIT];
    c.full  = w[FULL_BIT];
    c.width = w[WIDTH_LSB +: WIDTH_W];
    c.scale = w[SCALE_LSB +: SCALE_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input pwm_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[EN_BIT]                 = c.en;
    w[FULL_BIT]               = c.full;
    w[WIDTH_LSB +: WIDTH_W]   = c.width;
    w[SCALE_LSB +: SCALE_W]   = c.scale;
    return w;
  endfunction
endpackage

// File: rtl/pwm_cfg_reg.sv
`timescale 1ns/1ps
module pwm_cfg_reg
  import pwm_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output pwm_cfg_t         cfg,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] kept;
  pwm_cfg_t         cfg_q;

  assign kept = wdata & KEEP_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= word_to_cfg(kept);
    end
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_to_word(cfg_q);
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  // A tick fires on the last cycle of each divided interval.
  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_tick_counter.sv
`timescale 1ns/1ps
module pwm_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  // Wraps naturally after 2**CNT_W ticks, closing one period.
  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage #(
  parameter int CNT_W = 8
) (
  input  logic             en,
  input  logic             full,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] pos,
  output logic             level
);
  always_comb begin
    if (!en) begin
      level = 1'b0;
    end else if (full) begin
      level = 1'b1;
    end else begin
      level = (pos < width);
    end
  end
endmodule

// File: rtl/pwm_prescaled_ctl.sv
`timescale 1ns/1ps
module pwm_prescaled_ctl
  import pwm_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        pwm_out
);
  pwm_cfg_t           cfg;
  logic [SCALE_W-1:0] pre_cnt;
  logic [WIDTH_W-1:0] tick_cnt;
  logic               tick;

  pwm_cfg_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  // Any write, including one that flips enable, restarts both counters.
  pwm_prescaler #(.CNT_W(SCALE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clear (cfg_we),
    .run   (cfg.en),
    .limit (cfg.scale),
    .cnt   (pre_cnt),
    .tick  (tick)
  );

  pwm_tick_counter #(.CNT_W(WIDTH_W)) u_ticks (
    .clk   (clk),
    .rst   (rst),
    .clear (cfg_we),
    .run   (cfg.en),
    .tick  (tick),
    .cnt   (tick_cnt)
  );

  pwm_out_stage #(.CNT_W(WIDTH_W)) u_out (
    .en    (cfg.en),
    .full  (cfg.full),
    .width (cfg.width),
    .pos   (tick_cnt),
    .level (pwm_out)
  );
endmodule

// File: rtl/pwm_prescaled_ctl_chk.sv
`timescale 1ns/1ps
module pwm_prescaled_ctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic        wr_en_bit,
  input logic [31:0] cfg_rdata,
  input logic        pwm_out,
  input logic [12:0] pre_cnt,
  input logic [7:0]  tick_cnt
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[30:25] == 6'd0) && (cfg_rdata[15:13] == 3'd0));

  // R3
  pre_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= cfg_rdata[12:0]);

  // R3
  tick_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && cfg_rdata[31] && pre_cnt == cfg_rdata[12:0])
      |=> tick_cnt == $past(tick_cnt) + 8'd1);

  // R3
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && cfg_rdata[31] && pre_cnt != cfg_rdata[12:0])
      |=> $stable(tick_cnt));

  // R5
  zero_width_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[31] && !cfg_rdata[24] && cfg_rdata[23:16] == 8'd0) |-> !pwm_out);

  // R6
  full_duty_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[31] && cfg_rdata[24]) |-> pwm_out);

  // R7
  disable_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !wr_en_bit) |=> !pwm_out);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (pre_cnt == 13'd0) && (tick_cnt == 8'd0));
endmodule

bind pwm_prescaled_ctl pwm_prescaled_ctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .wr_en_bit (cfg_wdata[31]),
  .cfg_rdata (cfg_rdata),
  .pwm_out   (pwm_out),
  .pre_cnt   (pre_cnt),
  .tick_cnt  (tick_cnt)
);

// File: tb/pwm_prescaled_ctl_tb.sv
`timescale 1ns/1ps
module pwm_prescaled_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pwm_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [31:0] RD_MASK = 32'h81FF_1FFF;
  localparam int NV = 8;
  // Stimulus word, expected high cycles per period, period in cycles.
  localparam logic [31:0] V_CFG  [NV] = '{32'h8080_0000, 32'h8040_0001, 32'h8001_0003,
                                          32'h80FF_0002, 32'h8000_0000, 32'h8100_0001,
                                          32'h010A_0000, 32'hFEC8_E000};
  localparam int          V_HIGH [NV] = '{128, 128, 4, 765, 0, 512, 0, 200};
  localparam int          V_PER  [NV] = '{256, 512, 1024, 768, 256, 512, 256, 256};
  localparam string       V_REQ  [NV] = '{"R4", "R3", "R3", "R4", "R5", "R6", "R7", "R9"};

  always #5 clk = ~clk;

  pwm_prescaled_ctl u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pwm_out   (pwm_out)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Compares n samples from now against a waveform high for hi cycles per period.
  task automatic shape(input string req, input int hi, input int per, input int n);
    int errs = 0;
    int first = -1;
    for (int k = 0; k < n; k++) begin
      if (pwm_out !== ((k % per) < hi)) begin
        errs++;
        if (first < 0) first = k;
      end
      @(negedge clk);
    end
    check(req, errs == 0, first, -1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int hi_cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", pwm_out == 1'b0, pwm_out, 0);
    check("R1", cfg_rdata == 32'd0, cfg_rdata, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      wr(V_CFG[i]);
      check("R2", cfg_rdata == (V_CFG[i] & RD_MASK), cfg_rdata, V_CFG[i] & RD_MASK);
      shape(V_REQ[i], V_HIGH[i], V_PER[i], 2 * V_PER[i]);
    end

    // R7: disable in the middle of a high phase
    wr(32'h80C8_0000);
    repeat (50) @(negedge clk);
    check("R7", pwm_out == 1'b1, pwm_out, 1);
    wr(32'h00C8_0000);
    hi_cnt = 0;
    for (int k = 0; k < 300; k++) begin
      if (pwm_out) hi_cnt++;
      @(negedge clk);
    end
    check("R7", hi_cnt == 0, hi_cnt, 0);

    // R8: rewrite part way through the high phase restarts the period
    wr(32'h8064_0001);
    repeat (150) @(negedge clk);
    wr(32'h8064_0001);
    shape("R8", 200, 512, 512);

    // R8: rewrite in the low phase starts high at once
    wr(32'h8010_0000);
    repeat (100) @(negedge clk);
    check("R8", pwm_out == 1'b0, pwm_out, 0);
    wr(32'h80FF_0000);
    check("R8", pwm_out == 1'b1, pwm_out, 1);
    shape("R8", 255, 256, 256);

    // R1: reset in mid run
    wr(32'h8100_0000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", pwm_out == 1'b0, pwm_out, 0);
    check("R1", cfg_rdata == 32'd0, cfg_rdata, 0);
    rst = 1'b0;

    finish_run();
  end
endmodule